// File: doc/BRIEF.md
# Write-Only Two-Wire Control Receiver for a Frequency Synthesizer

This block is a two-wire bus slave that takes in write transfers and turns them into the control words of a frequency synthesizer. It watches oversampled clock and data lines on the system clock and answers its own 7-bit address. The top five address bits are fixed at 1,1,0,0,0 and the last two come from a strap input, so four such devices can share one bus. Each received byte is acknowledged, and the byte is stored in one of four staging registers chosen by a byte pointer.

The first data byte of a transfer chooses the entry point. When its most significant bit is 0, that byte is the divider-high byte. When its most significant bit is 1, that byte is the control byte that also holds the divider top bits. After that the pointer steps through the four byte slots and wraps around. The staged 17-bit divider ratio and the two control fields reach the active outputs only when a complete set of four bytes has arrived since the last START, or when a STOP ends a transfer that carried data. This lets a host sweep the frequency without glitching the active ratio.

Top module: `synth_ctl_rx`

## Requirements
- R1: The slave acknowledges an address byte equal to {1,1,0,0,0, addr_sel[1], addr_sel[0], 0}, sent MSB first. The last bit is the write flag, and 0 means write.
- R2: An address byte that does not match, or one whose last bit is 1, gets no acknowledge. Every byte after it is also ignored, with no acknowledge and no change to the outputs, until the next START or STOP.
- R3: Every data byte of a matched write is acknowledged. sda_pull is high only during the acknowledge clock slot and is low again once that slot's SCL falls.
- R4: The MSB of the first data byte after the address picks the slot. A 0 selects slot A (divider high) and a 1 selects slot C (divider top plus control).
- R5: After each data byte the pointer moves to the next slot in the order A, B, C, D, and from D it wraps back to A. Bytes are accepted until STOP without re-addressing.
- R6: The fields map as follows. Slot A bits[6:0] give ratio[14:8]. Slot B bits[7:0] give ratio[7:0]. Slot C bits[6:5] give ratio[16:15] and slot C bits[4:0] give cfg_a. Slot D bits[7:0] give cfg_b.
- R7: Once all four slots have been written since the last START, the staged values are copied to div_ratio, cfg_a and cfg_b before any STOP.
- R8: A STOP copies the staged values to the outputs if any data byte has arrived since the last copy.
- R9: A repeated START commits nothing. Writing slots A and B again inside a transfer leaves the outputs unchanged until a STOP.
- R10: After reset, div_ratio, cfg_a, cfg_b and sda_pull are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| addr_sel | input | 2 | Strap value for the two low address bits |
| sda_pull | output | 1 | Drives the data line low (acknowledge) |
| div_ratio | output | 17 | Active divider ratio |
| cfg_a | output | 5 | Active control field taken from slot C |
| cfg_b | output | 8 | Active control field taken from slot D |

## Verification
The hardest case to reach from the ports is a transfer that writes slots A and B, then issues a repeated START, then writes A and B again. The outputs must stay frozen across both halves even though the staging registers have changed. The bench builds this case from bit-level tasks that drive the open-drain lines. It checks the outputs between the repeated START and the STOP, and then again after the STOP. A second hard case is the wrap past slot D. Here a commit happens in the middle of the transfer, and the trailing slot-C byte is committed only by the STOP.

// File: rtl/synth_ctl_pkg.sv
// Shared constants and types for the synthesizer control receiver.
// Assumes a 7-bit address with a fixed upper part and a 2-bit strap part.
package synth_ctl_pkg;
    localparam int DIV_W    = 17;
    localparam int CFGA_W   = 5;
    localparam int CFGB_W   = 8;
    localparam int SEL_W    = 2;
    localparam int SLOTS    = 4;
    localparam int PTR_W    = $clog2(SLOTS);
    localparam logic [6-SEL_W:0] ADDR_FIXED = 5'b11000;

    typedef enum logic [1:0] {BE_IDLE, BE_RECV, BE_ACK, BE_IGNORE} be_state_t;

    typedef struct packed {
        logic [DIV_W-1:0]  ratio;
        logic [CFGA_W-1:0] cfg_a;
        logic [CFGB_W-1:0] cfg_b;
    } synth_word_t;
endpackage

// File: rtl/i2c_line_sampler.sv
// Brings SCL and SDA into the clock domain through a synchronizer chain.
// Produces single-cycle edge and START/STOP events.
// Assumes clk runs at least 8x faster than SCL and the idle bus is high.
module i2c_line_sampler #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_now,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_DEPTH-1:0] scl_sync, sda_sync;
    logic scl_q, sda_q, scl_s, sda_s;

    // synchronizer chains, resetting to the idle-high bus level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
        end else begin
            scl_sync <= {scl_sync[SYNC_DEPTH-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_DEPTH-2:0], sda_in};
        end
    end

    assign scl_s = scl_sync[SYNC_DEPTH-1];
    assign sda_s = sda_sync[SYNC_DEPTH-1];

    // previous-sample registers used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign sda_now   = sda_s;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
// Shifts in bytes MSB first and matches the address byte.
// Drives the acknowledge pull-down and hands each data byte onward.
// Assumes a write-only slave: when the address misses, or the
// read flag is set, it stays silent until the next START or STOP.
module i2c_byte_engine
    import synth_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_now,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic [SEL_W-1:0] addr_sel,
    output logic             sda_pull,
    output logic             byte_valid,
    output logic [7:0]       byte_data
);
    be_state_t  state;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       is_addr;
    logic       addr_hit;

    assign addr_hit = (shreg[7:1] == {ADDR_FIXED, addr_sel}) && !shreg[0];

    // bus protocol state machine: receive, acknowledge, ignore
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= BE_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            is_addr    <= 1'b0;
            sda_pull   <= 1'b0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (start_evt) begin
                state    <= BE_RECV;
                bitcnt   <= '0;
                is_addr  <= 1'b1;
                sda_pull <= 1'b0;
            end else if (stop_evt) begin
                state    <= BE_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    BE_RECV: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda_now};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (is_addr) begin
                                if (addr_hit) begin
                                    sda_pull <= 1'b1;
                                    state    <= BE_ACK;
                                end else begin
                                    state    <= BE_IGNORE;
                                end
                            end else begin
                                byte_valid <= 1'b1;
                                byte_data  <= shreg;
                                sda_pull   <= 1'b1;
                                state      <= BE_ACK;
                            end
                        end
                    end
                    BE_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= BE_RECV;
                            bitcnt   <= '0;
                            is_addr  <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: the pull-down is asserted only in the acknowledge state
    p_pull_in_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> state == BE_ACK);
    // R3: the pull-down rises only after a full 8-bit byte
    p_ack_after_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(bitcnt) == 4'd8);
    // R2: an ignored transfer never acknowledges and never emits bytes
    p_ignore_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == BE_IGNORE |=> !sda_pull && !byte_valid);
endmodule

// File: rtl/synth_reg_bank.sv
// Holds the byte pointer and the staging registers, and commits the
// staged set to the active outputs according to end-of-transfer rules.
// Assumes byte_valid pulses are many cycles apart (one per bus byte).
module synth_reg_bank
    import synth_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              start_evt,
    input  logic              stop_evt,
    output logic [DIV_W-1:0]  div_ratio,
    output logic [CFGA_W-1:0] cfg_a,
    output logic [CFGB_W-1:0] cfg_b
);
    localparam logic [PTR_W-1:0] SLOT_A = PTR_W'(0);
    localparam logic [PTR_W-1:0] SLOT_C = PTR_W'(2);

    synth_word_t       stage, active;
    logic [PTR_W-1:0]  ptr, idx;
    logic [SLOTS-1:0]  seen, seen_next;
    logic              first_pend, pending, commit_q;

    // slot of the incoming byte: entry choice on the first byte, pointer after
    assign idx       = first_pend ? (byte_data[7] ? SLOT_C : SLOT_A) : ptr;
    assign seen_next = seen | (SLOTS'(1) << idx);

    // pointer, staging writes and commit requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage      <= '0;
            ptr        <= '0;
            seen       <= '0;
            first_pend <= 1'b1;
            pending    <= 1'b0;
            commit_q   <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (start_evt) begin
                first_pend <= 1'b1;
                seen       <= '0;
            end else if (stop_evt) begin
                commit_q   <= pending;
                pending    <= 1'b0;
                seen       <= '0;
                first_pend <= 1'b1;
            end else if (byte_valid) begin
                case (idx)
                    2'd0:    stage.ratio[14:8] <= byte_data[6:0];
                    2'd1:    stage.ratio[7:0]  <= byte_data;
                    2'd2: begin
                             stage.ratio[16:15] <= byte_data[6:5];
                             stage.cfg_a        <= byte_data[4:0];
                    end
                    default: stage.cfg_b <= byte_data;
                endcase
                ptr        <= idx + PTR_W'(1);
                first_pend <= 1'b0;
                if (&seen_next) begin
                    commit_q <= 1'b1;
                    seen     <= '0;
                    pending  <= 1'b0;
                end else begin
                    seen     <= seen_next;
                    pending  <= 1'b1;
                end
            end
        end
    end

    // active register: loads the staged set on a commit request
    always_ff @(posedge clk) begin
        if (!rst_n)        active <= '0;
        else if (commit_q) active <= stage;
    end

    assign div_ratio = active.ratio;
    assign cfg_a     = active.cfg_a;
    assign cfg_b     = active.cfg_b;

    // R5: a non-entry byte advances the pointer by one slot with wrap
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !first_pend && !start_evt && !stop_evt)
        |=> ptr == $past(ptr) + PTR_W'(1));
    // R9: outputs change only through a commit
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_q |=> $stable(active));
    // R7: a commit copies exactly the staged set
    p_commit_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> active == $past(stage));
endmodule

// File: rtl/synth_ctl_rx.sv
// Top level of the write-only synthesizer control receiver.
// Connects the line sampler, the byte engine and the register bank.
// Assumes an external open-drain driver turns sda_pull into a low on SDA.
module synth_ctl_rx
    import synth_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [SEL_W-1:0]  addr_sel,
    output logic              sda_pull,
    output logic [DIV_W-1:0]  div_ratio,
    output logic [CFGA_W-1:0] cfg_a,
    output logic [CFGB_W-1:0] cfg_b
);
    logic scl_rise, scl_fall, sda_now, start_evt, stop_evt;
    logic byte_valid;
    logic [7:0] byte_data;

    i2c_line_sampler #(.SYNC_DEPTH(2)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_now(sda_now),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2c_byte_engine u_engine (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_now(sda_now), .start_evt(start_evt), .stop_evt(stop_evt),
        .addr_sel(addr_sel), .sda_pull(sda_pull),
        .byte_valid(byte_valid), .byte_data(byte_data)
    );

    synth_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
        .byte_data(byte_data), .start_evt(start_evt), .stop_evt(stop_evt),
        .div_ratio(div_ratio), .cfg_a(cfg_a), .cfg_b(cfg_b)
    );
endmodule

// File: tb/synth_ctl_rx_tb.sv
module synth_ctl_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b10;
    logic sda_pull;
    logic [16:0] div_ratio;
    logic [4:0] cfg_a;
    logic [7:0] cfg_b;
    logic sda_bus;
    int n_checks = 0;
    int n_fail = 0;
    bit ack;

    assign sda_bus = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_ctl_rx u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .addr_sel(addr_sel), .sda_pull(sda_pull),
        .div_ratio(div_ratio), .cfg_a(cfg_a), .cfg_b(cfg_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [16:0] r, input logic [4:0] a, input logic [7:0] b);
        chk({req, " ratio"}, 32'(div_ratio), 32'(r));
        chk({req, " cfg_a"}, 32'(cfg_a), 32'(a));
        chk({req, " cfg_b"}, 32'(cfg_b), 32'(b));
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(3);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(1);
            scl_m = 1'b1; wq(2);
            scl_m = 1'b0; wq(1);
        end
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        acked = !sda_bus;
        wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic t_reset();
        chk_out("R10 reset", 17'h0, 5'h0, 8'h0);
        chk("R10 reset pull", 32'(sda_pull), 32'd0);
    endtask

    task automatic t_full_set();
        bus_start();
        send_byte(8'hC4, ack); chk("R1 address ack", 32'(ack), 32'd1);
        chk("R3 pull released after ack", 32'(sda_pull), 32'd0);
        send_byte(8'h35, ack); chk("R3 data ack A", 32'(ack), 32'd1);
        send_byte(8'hA7, ack); chk("R3 data ack B", 32'(ack), 32'd1);
        send_byte(8'hC9, ack); chk("R3 data ack C", 32'(ack), 32'd1);
        chk_out("R7 before set complete", 17'h0, 5'h0, 8'h0);
        send_byte(8'h5E, ack); chk("R3 data ack D", 32'(ack), 32'd1);
        chk_out("R7 R6 commit before stop", {2'b10, 7'h35, 8'hA7}, 5'h09, 8'h5E);
        bus_stop();
        chk_out("R8 stop after commit", {2'b10, 7'h35, 8'hA7}, 5'h09, 8'h5E);
    endtask

    task automatic t_ab_stop();
        bus_start();
        send_byte(8'hC4, ack);
        send_byte(8'h12, ack);
        send_byte(8'h34, ack);
        chk_out("R8 held before stop", {2'b10, 7'h35, 8'hA7}, 5'h09, 8'h5E);
        bus_stop();
        chk_out("R8 R4 A,B then stop", {2'b10, 7'h12, 8'h34}, 5'h09, 8'h5E);
    endtask

    task automatic t_c_stop();
        bus_start();
        send_byte(8'hC4, ack);
        send_byte(8'hA3, ack);
        bus_stop();
        chk_out("R4 R8 C then stop", {2'b01, 7'h12, 8'h34}, 5'h03, 8'h5E);
    endtask

    task automatic t_wrap();
        bus_start();
        send_byte(8'hC4, ack);
        send_byte(8'hE1, ack);
        send_byte(8'h77, ack);
        send_byte(8'h0F, ack);
        send_byte(8'h80, ack);
        chk_out("R5 R7 C,D,A,B commit", {2'b11, 7'h0F, 8'h80}, 5'h01, 8'h77);
        send_byte(8'h9F, ack);
        chk("R5 wrap byte acked", 32'(ack), 32'd1);
        chk_out("R5 wrapped C staged only", {2'b11, 7'h0F, 8'h80}, 5'h01, 8'h77);
        bus_stop();
        chk_out("R8 R5 wrapped C on stop", {2'b00, 7'h0F, 8'h80}, 5'h1F, 8'h77);
    endtask

    task automatic t_restart();
        bus_start();
        send_byte(8'hC4, ack);
        send_byte(8'h55, ack);
        send_byte(8'h66, ack);
        bus_rstart();
        send_byte(8'hC4, ack); chk("R1 ack after repeated start", 32'(ack), 32'd1);
        chk_out("R9 no commit on repeated start", {2'b00, 7'h0F, 8'h80}, 5'h1F, 8'h77);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        chk_out("R9 repeated A,B held", {2'b00, 7'h0F, 8'h80}, 5'h1F, 8'h77);
        bus_stop();
        chk_out("R9 R8 commit at stop", {2'b00, 7'h11, 8'h22}, 5'h1F, 8'h77);
    endtask

    task automatic t_mismatch();
        bus_start();
        send_byte(8'hC6, ack); chk("R2 wrong address nack", 32'(ack), 32'd0);
        send_byte(8'h7F, ack); chk("R2 ignored data nack", 32'(ack), 32'd0);
        send_byte(8'h40, ack);
        bus_stop();
        chk_out("R2 ignored transfer", {2'b00, 7'h11, 8'h22}, 5'h1F, 8'h77);
        bus_start();
        send_byte(8'hC5, ack); chk("R2 read flag nack", 32'(ack), 32'd0);
        send_byte(8'h01, ack); chk("R2 read data nack", 32'(ack), 32'd0);
        bus_stop();
        chk_out("R2 read ignored", {2'b00, 7'h11, 8'h22}, 5'h1F, 8'h77);
    endtask

    task automatic t_strap();
        addr_sel = 2'b11;
        wq(1);
        bus_start();
        send_byte(8'hC6, ack); chk("R1 strap 11 ack", 32'(ack), 32'd1);
        send_byte(8'h01, ack);
        bus_stop();
        chk_out("R1 R8 strap 11 write", {2'b00, 7'h01, 8'h22}, 5'h1F, 8'h77);
        bus_start();
        send_byte(8'hC4, ack); chk("R1 old address now nack", 32'(ack), 32'd0);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_full_set();
        t_ab_stop();
        t_c_stop();
        t_wrap();
        t_restart();
        t_mismatch();
        t_strap();
        finish_run();
    end
endmodule